// File: doc/BRIEF.md
# Coprocessor Register Write Formatter

This block is the register-access front end of a geometry coprocessor. It holds two 32-entry register files, one for data and one for control, and sits between the host CPU's register-move and memory-load paths and those files. A write carries a 5-bit index, a file select and a 32-bit value. The block reshapes the value according to the destination index and stores it in one clock. Some data registers keep only a signed or unsigned halfword. Three data indices also raise a one-cycle side-effect strobe that tells the downstream arithmetic which register was touched.

Reads come in with an index, a file select and the host destination register. The block answers one cycle later with the stored value and echoes the destination. It drops any read aimed at host register 0. For the one data index whose read needs extra handling it raises a flag with the response. A move and a load present the same write port, so both sources are formatted identically.

Top module: `cpx_regport`

## Requirements
- R1: A write to data index 8, 9, 10 or 11 stores bits 15:0 of the value sign-extended to 32 bits (bit 15 copied into bits 31:16).
- R2: A write to data index 16, 17, 18 or 19 stores bits 15:0 of the value with bits 31:16 cleared.
- R3: A write to data index 15, 28 or 30 stores the full value, and in the next cycle `fx_valid` is high for exactly that one cycle with `fx_idx` equal to the written index. Writes to any other index, and writes to the control file, never raise `fx_valid`.
- R4: A write to any data index not named in R1 to R3 stores the full 32-bit value unchanged.
- R5: A write to the control file (`wr_ctrl`=1) stores the full 32-bit value at any index, including indices that R1 and R2 reshape in the data file.
- R6: An accepted read with a non-zero `rd_dest` produces `rsp_valid` for one cycle in the next clock. `rsp_data` carries the addressed register and `rsp_dest` echoes `rd_dest`.
- R7: `rsp_special` is high with a response exactly when the read was of data index 29. Control index 29 and every other index give 0, and it is 0 whenever `rsp_valid` is 0.
- R8: A read with `rd_dest` equal to 0 produces no response (`rsp_valid` stays 0 in the following cycle).
- R9: Synchronous active-low reset clears every register of both files to zero and drives `rsp_valid`, `rsp_special`, `fx_valid`, `wr_ready` and `rd_ready` low.
- R10: From the cycle after reset is released, `wr_ready` and `rd_ready` stay high. A write takes effect at its accepting edge and is visible to a read issued in the next cycle. A read accepted in the same cycle as a write to the same register returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write port can accept |
| wr_ctrl | input | 1 | 1 selects the control file, 0 the data file |
| wr_idx | input | 5 | Register index to write |
| wr_data | input | 32 | Value from a register move or a memory load |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read port can accept |
| rd_ctrl | input | 1 | 1 selects the control file, 0 the data file |
| rd_idx | input | 5 | Register index to read |
| rd_dest | input | 5 | Host destination register, 0 discards the read |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 32 | Value read |
| rsp_dest | output | 5 | Echoed host destination |
| rsp_special | output | 1 | Response needs the special read handling |
| fx_valid | output | 1 | Side-effect strobe after a write to index 15, 28 or 30 |
| fx_idx | output | 5 | Index that raised the strobe |

## Verification
The checker watches the port-level timing on every cycle. It checks that a strobe follows exactly the qualifying writes, carries the written index and lasts one cycle, and that responses follow only accepted reads with a non-zero destination. It also checks that the special flag tracks data index 29 and that both ready outputs stay high once out of reset. Stored values can only be seen through reads, so the bench's scenarios carry the data checks. These cover the halfword sign and zero extension with bit 15 both set and clear, full-width storage in both files, the cleared state after reset, and read-during-write ordering.

// File: rtl/cpx_pkg.sv
// Shared definitions for the coprocessor register port.
// Assumes 32 registers per file, 32-bit registers and halfword-wide narrow registers.
package cpx_pkg;
    localparam int IDX_W   = 5;
    localparam int DATA_W  = 32;
    localparam int HALF_W  = 16;
    localparam int NREGS   = 1 << IDX_W;

    // How a data-file write is shaped before it is stored
    typedef enum logic [1:0] {
        WF_FULL = 2'd0,
        WF_SEXT = 2'd1,
        WF_ZEXT = 2'd2,
        WF_SIDE = 2'd3
    } wfmt_e;

    // Data index whose read needs the special path
    localparam logic [IDX_W-1:0] RD_SPECIAL_IDX = 5'd29;

    // Classify a data-file index by the shaping it needs
    function automatic wfmt_e wfmt_of(input logic [IDX_W-1:0] idx);
        wfmt_e k;
        case (idx)
            5'd8, 5'd9, 5'd10, 5'd11:   k = WF_SEXT;
            5'd16, 5'd17, 5'd18, 5'd19: k = WF_ZEXT;
            5'd15, 5'd28, 5'd30:        k = WF_SIDE;
            default:                    k = WF_FULL;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/cpx_wfmt.sv
// Write formatter: shapes an incoming value for its destination register.
// Assumes HW < W. Purely combinational. Control-file writes pass through
// unchanged, and the side-effect hit is raised only for data-file targets.
module cpx_wfmt
    import cpx_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int HW = HALF_W,
    parameter int IW = IDX_W
) (
    input  logic [IW-1:0] idx,
    input  logic          to_ctrl,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic          side_hit
);
    localparam int EXT_W = W - HW;

    wfmt_e kind;

    // Pick the shaping rule for this target
    always_comb begin
        kind = to_ctrl ? WF_FULL : wfmt_of(idx);
    end

    // Apply the rule to the value
    always_comb begin
        case (kind)
            WF_SEXT: dout = {{EXT_W{din[HW-1]}}, din[HW-1:0]};
            WF_ZEXT: dout = {{EXT_W{1'b0}}, din[HW-1:0]};
            default: dout = din;
        endcase
        side_hit = (kind == WF_SIDE);
    end
endmodule

// File: rtl/cpx_regfile.sv
// Register file with one write port and one combinational read port.
// Assumes a synchronous active-low reset that clears every entry.
// Each entry is its own register, built by a generate loop.
module cpx_regfile #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Hold one entry, updated when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= '0;
            else if (we && (waddr == AW'(g)))
                ent[g] <= wdata;
        end
    end

    // Select the addressed entry
    always_comb begin
        rdata = ent[raddr];
    end
endmodule

// File: rtl/cpx_rdport.sv
// Read response stage: registers the selected value, the echoed destination
// and the special-read flag. A request with destination zero yields nothing.
// Assumes the register-file outputs are the values before this edge's write.
module cpx_rdport
    import cpx_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          sel_ctrl,
    input  logic [IW-1:0] idx,
    input  logic [IW-1:0] dest,
    input  logic [W-1:0]  dfile_q,
    input  logic [W-1:0]  cfile_q,
    output logic          rsp_valid,
    output logic [W-1:0]  rsp_data,
    output logic [IW-1:0] rsp_dest,
    output logic          rsp_special
);
    logic live;
    logic spec;

    // Decide whether the request produces a response and if it is special
    always_comb begin
        live = req && (dest != '0);
        spec = !sel_ctrl && (idx == IW'(RD_SPECIAL_IDX));
    end

    // Register the response strobe and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_special <= 1'b0;
        end else begin
            rsp_valid   <= live;
            rsp_special <= live && spec;
        end
    end

    // Register the response payload only when a response is produced
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data <= '0;
            rsp_dest <= '0;
        end else if (live) begin
            rsp_data <= sel_ctrl ? cfile_q : dfile_q;
            rsp_dest <= dest;
        end
    end
endmodule

// File: rtl/cpx_regport.sv
// Top of the coprocessor register port: formats and commits writes to the
// data or control file, raises the side-effect strobe, and serves reads.
// Assumes both request ports are sampled every cycle once ready is high.
module cpx_regport
    import cpx_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int HW = HALF_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic          wr_ctrl,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic          rd_ctrl,
    input  logic [IW-1:0] rd_idx,
    input  logic [IW-1:0] rd_dest,
    output logic          rsp_valid,
    output logic [W-1:0]  rsp_data,
    output logic [IW-1:0] rsp_dest,
    output logic          rsp_special,
    output logic          fx_valid,
    output logic [IW-1:0] fx_idx
);
    localparam int DEPTH = 1 << IW;

    logic          rdy_q;
    logic          wr_go, rd_go;
    logic [W-1:0]  wr_shaped;
    logic          side_hit;
    logic [W-1:0]  dq, cq;

    // Ready rises the cycle after reset is released
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= 1'b1;
    end

    // Accepted handshakes
    always_comb begin
        wr_ready = rdy_q;
        rd_ready = rdy_q;
        wr_go    = wr_valid && rdy_q;
        rd_go    = rd_valid && rdy_q;
    end

    cpx_wfmt #(.W(W), .HW(HW), .IW(IW)) u_fmt (
        .idx      (wr_idx),
        .to_ctrl  (wr_ctrl),
        .din      (wr_data),
        .dout     (wr_shaped),
        .side_hit (side_hit)
    );

    cpx_regfile #(.DEPTH(DEPTH), .W(W), .AW(IW)) u_dfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_go && !wr_ctrl),
        .waddr (wr_idx),
        .wdata (wr_shaped),
        .raddr (rd_idx),
        .rdata (dq)
    );

    cpx_regfile #(.DEPTH(DEPTH), .W(W), .AW(IW)) u_cfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_go && wr_ctrl),
        .waddr (wr_idx),
        .wdata (wr_shaped),
        .raddr (rd_idx),
        .rdata (cq)
    );

    cpx_rdport #(.W(W), .IW(IW)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (rd_go),
        .sel_ctrl    (rd_ctrl),
        .idx         (rd_idx),
        .dest        (rd_dest),
        .dfile_q     (dq),
        .cfile_q     (cq),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_dest    (rsp_dest),
        .rsp_special (rsp_special)
    );

    // One-cycle side-effect strobe carrying the written index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fx_valid <= 1'b0;
            fx_idx   <= '0;
        end else begin
            fx_valid <= wr_go && side_hit;
            if (wr_go && side_hit)
                fx_idx <= wr_idx;
        end
    end
endmodule

// File: rtl/cpx_regport_chk.sv
// Port-level protocol checks for cpx_regport, attached with bind.
module cpx_regport_chk #(
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic          wr_ctrl,
    input logic [IW-1:0] wr_idx,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic          rd_ctrl,
    input logic [IW-1:0] rd_idx,
    input logic [IW-1:0] rd_dest,
    input logic          rsp_valid,
    input logic [IW-1:0] rsp_dest,
    input logic          rsp_special,
    input logic          fx_valid,
    input logic [IW-1:0] fx_idx
);
    logic fx_cand;
    always_comb begin
        fx_cand = wr_valid && wr_ready && !wr_ctrl &&
                  (wr_idx == IW'(15) || wr_idx == IW'(28) || wr_idx == IW'(30));
    end

    a_r3_fx_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        fx_valid == $past(fx_cand));

    a_r3_fx_carries_idx: assert property (@(posedge clk) disable iff (!rst_n)
        fx_valid |-> fx_idx == $past(wr_idx));

    a_r6_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(rd_valid && rd_ready && rd_dest != '0));

    a_r6_dest_echo: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_dest == $past(rd_dest));

    a_r8_no_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_dest != '0);

    a_r7_special_tracks_idx: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_special |-> (rsp_valid && $past(!rd_ctrl && rd_idx == IW'(29))));

    a_r10_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wr_ready && rd_ready));
endmodule

bind cpx_regport cpx_regport_chk #(.IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_ctrl     (wr_ctrl),
    .wr_idx      (wr_idx),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_ctrl     (rd_ctrl),
    .rd_idx      (rd_idx),
    .rd_dest     (rd_dest),
    .rsp_valid   (rsp_valid),
    .rsp_dest    (rsp_dest),
    .rsp_special (rsp_special),
    .fx_valid    (fx_valid),
    .fx_idx      (fx_idx)
);

// File: tb/cpx_regport_test.sv
// Bench: behavioural reference model compared against the design on every clock.
module cpx_regport_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, wr_ctrl = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid = 1'b0, rd_ctrl = 1'b0;
    logic [4:0]  rd_idx = '0, rd_dest = '0;
    logic        wr_ready, rd_ready, rsp_valid, rsp_special, fx_valid;
    logic [31:0] rsp_data;
    logic [4:0]  rsp_dest, fx_idx;

    cpx_regport uut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_ctrl(wr_ctrl),
        .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_ctrl(rd_ctrl),
        .rd_idx(rd_idx), .rd_dest(rd_dest),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_dest(rsp_dest),
        .rsp_special(rsp_special), .fx_valid(fx_valid), .fx_idx(fx_idx)
    );

    // Reference state
    logic [31:0] dref [32];
    logic [31:0] cref [32];
    logic        e_ready = 1'b0, e_rv = 1'b0, e_rs = 1'b0, e_fx = 1'b0;
    logic [31:0] e_rd = '0;
    logic [4:0]  e_dest = '0, e_fxi = '0;
    int vectors = 0, bad = 0;
    bit finished = 1'b0;

    // Expected stored value from the requirements
    function automatic logic [31:0] shape(input bit ctrl, input int idx, input logic [31:0] v);
        if (ctrl) return v;                                        // R5
        if (idx >= 8 && idx <= 11) return {{16{v[15]}}, v[15:0]};  // R1
        if (idx >= 16 && idx <= 19) return {16'h0, v[15:0]};       // R2
        return v;                                                  // R3, R4
    endfunction

    function automatic string tag_of(input bit ctrl, input int idx);
        if (ctrl) return "R5";
        if (idx >= 8 && idx <= 11) return "R1";
        if (idx >= 16 && idx <= 19) return "R2";
        if (idx == 15 || idx == 28 || idx == 30) return "R3";
        return "R4";
    endfunction

    // One clock: advance the model at the edge, compare away from it
    task automatic tick(input string tag);
        bit miss;
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin dref[i] = '0; cref[i] = '0; end
            e_ready = 1'b0; e_rv = 1'b0; e_rs = 1'b0; e_fx = 1'b0;
        end else begin
            e_rv = rd_valid && e_ready && (rd_dest != 0);
            e_rs = e_rv && !rd_ctrl && (rd_idx == 29);
            if (e_rv) begin
                e_rd   = rd_ctrl ? cref[rd_idx] : dref[rd_idx];
                e_dest = rd_dest;
            end
            e_fx = wr_valid && e_ready && !wr_ctrl &&
                   (wr_idx == 15 || wr_idx == 28 || wr_idx == 30);
            if (e_fx) e_fxi = wr_idx;
            if (wr_valid && e_ready) begin
                if (wr_ctrl) cref[wr_idx] = shape(1'b1, wr_idx, wr_data);
                else         dref[wr_idx] = shape(1'b0, wr_idx, wr_data);
            end
            e_ready = 1'b1;
        end
        @(negedge clk);
        vectors++;
        miss = 1'b0;
        if (wr_ready !== e_ready || rd_ready !== e_ready) begin
            miss = 1'b1;
            $display("FAIL %s ready: actual %b/%b expected %b", tag, wr_ready, rd_ready, e_ready);
        end
        if (rsp_valid !== e_rv) begin
            miss = 1'b1;
            $display("FAIL %s rsp_valid: actual %b expected %b", tag, rsp_valid, e_rv);
        end
        if (rsp_special !== e_rs) begin
            miss = 1'b1;
            $display("FAIL %s rsp_special: actual %b expected %b", tag, rsp_special, e_rs);
        end
        if (e_rv && (rsp_data !== e_rd || rsp_dest !== e_dest)) begin
            miss = 1'b1;
            $display("FAIL %s rsp data/dest: actual %h/%0d expected %h/%0d",
                     tag, rsp_data, rsp_dest, e_rd, e_dest);
        end
        if (fx_valid !== e_fx || (e_fx && fx_idx !== e_fxi)) begin
            miss = 1'b1;
            $display("FAIL %s fx: actual %b/%0d expected %b/%0d", tag, fx_valid, fx_idx, e_fx, e_fxi);
        end
        if (miss) bad++;
    endtask

    task automatic idle(input string tag);
        wr_valid = 1'b0; rd_valid = 1'b0;
        tick(tag);
    endtask

    task automatic wr(input bit ctrl, input int idx, input logic [31:0] v, input string tag);
        wr_valid = 1'b1; wr_ctrl = ctrl; wr_idx = 5'(idx); wr_data = v;
        rd_valid = 1'b0;
        tick(tag);
        wr_valid = 1'b0;
    endtask

    task automatic rd(input bit ctrl, input int idx, input int dest, input string tag);
        rd_valid = 1'b1; rd_ctrl = ctrl; rd_idx = 5'(idx); rd_dest = 5'(dest);
        wr_valid = 1'b0;
        tick(tag);
        rd_valid = 1'b0;
    endtask

    // Write all of one file, then read it all back
    task automatic sweep(input bit ctrl, input logic [31:0] base);
        for (int i = 0; i < 32; i++) wr(ctrl, i, base + 32'(i), tag_of(ctrl, i));
        for (int i = 0; i < 32; i++) rd(ctrl, i, (i % 31) + 1, tag_of(ctrl, i));
        idle("R6");
    endtask

    initial begin
        // R9: reset state, held for several clocks
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) tick("R9");
        rst_n = 1'b1;
        idle("R10");
        for (int i = 0; i < 32; i++) rd(1'b0, i, 3, "R9");
        for (int i = 0; i < 32; i++) rd(1'b1, i, 4, "R9");
        idle("R9");
        // R1 R2 R4 R3: halfword bit 15 set, then clear
        sweep(1'b0, 32'hDEAD_8000);
        sweep(1'b0, 32'h1234_7F00);
        // R5: control file keeps full width at every index
        sweep(1'b1, 32'hCAFE_9100);
        // R8: reads with destination 0 are dropped
        rd(1'b0, 5, 0, "R8");
        rd(1'b0, 29, 0, "R8");
        idle("R8");
        // R7: special read flag only for data index 29
        rd(1'b0, 29, 7, "R7");
        rd(1'b1, 29, 7, "R7");
        rd(1'b0, 28, 7, "R7");
        idle("R7");
        // R3: back-to-back strobing writes, then a non-strobing one
        wr(1'b0, 15, 32'h0000_0001, "R3");
        wr(1'b0, 28, 32'h0000_0002, "R3");
        wr(1'b0, 30, 32'h0000_0003, "R3");
        wr(1'b1, 15, 32'h0000_0004, "R3");
        wr(1'b0, 14, 32'h0000_0005, "R3");
        idle("R3");
        // R10: read in the same cycle as a write to the same register
        wr_valid = 1'b1; wr_ctrl = 1'b0; wr_idx = 5'd9; wr_data = 32'h5555_ABCD;
        rd_valid = 1'b1; rd_ctrl = 1'b0; rd_idx = 5'd9; rd_dest = 5'd2;
        tick("R10");
        rd(1'b0, 9, 2, "R10");
        idle("R10");
        // R9: reset mid-run clears everything again
        rst_n = 1'b0;
        tick("R9");
        tick("R9");
        rst_n = 1'b1;
        idle("R9");
        rd(1'b0, 9, 1, "R9");
        rd(1'b1, 31, 1, "R9");
        idle("R9");
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
            $finish;
        end
    end
endmodule